// File: doc/BRIEF.md
# Operand Dependency Hazard Detector

This block looks at a stream of issued instructions, one per cycle, and reports whether each one needs the result of the instruction that issued in the cycle just before it. The decoder presents each instruction as an operand descriptor. The descriptor gives a destination kind with a register index, up to `N_SRC` source slots that each have a kind and a register index, and two bits that mark a write and a read of the condition flag. The block keeps the descriptor of the previous valid instruction and compares it with the one that is presented now. It gives one registered hazard bit per cycle. Stall logic outside the block uses this bit to hold issue.

The rules are deliberately conservative where addresses are unknown. Two memory operands always conflict, because a store must complete before a following load, and no address comparison is made. Immediates never conflict. A flag write followed by a flag read always conflicts. Register index 0 always reads as zero, so a match on it is never reported. A saturating counter records how many valid pairs were found to be hazardous.

Operand kind encoding, used in each 2-bit kind field: 0 = unused, 1 = immediate, 2 = register direct, 3 = memory (base register plus displacement). Source slot i uses kind bits [2i+1:2i] and index bits [IDX_W*i +: IDX_W]. A destination of kind 0 or 1 writes nothing.

Top module: `operand_hazard_det`

## Requirements
- R1: While reset is asserted and after its release, before any pair is evaluated, `hazard_out` is 0 and `hazard_cnt_out` is 0.
- R2: A source slot of kind immediate (1) or unused (0) never causes a hazard, whatever its index.
- R3: A register-direct source (2) conflicts with a previous register-direct destination (2) exactly when the two indices are equal and non-zero.
- R4: A register-direct source never conflicts with a previous memory destination (3).
- R5: A memory source (3) always conflicts with a previous memory destination (3), whatever the two indices are.
- R6: A memory source whose base index equals a previous register-direct destination index, with that index non-zero, conflicts.
- R7: If the previous instruction writes the flag and the current one reads it, a hazard is reported regardless of operands.
- R8: An index match on register 0 never causes a hazard.
- R9: A pair is evaluated only when `valid_in` is high in two consecutive cycles. A cycle with `valid_in` low gives `hazard_out` = 0 and leaves the next valid instruction with no predecessor.
- R10: `hazard_out` shows the verdict for the pair presented in the previous cycle (one register of latency).
- R11: `hazard_cnt_out` increases by one in the same cycle that `hazard_out` rises for a pair, and it saturates at all ones instead of wrapping.
- R12: Every source slot is examined, and a conflict in any slot is enough to report a hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | A descriptor is presented this cycle |
| dst_kind_in | input | 2 | Destination kind |
| dst_idx_in | input | IDX_W | Destination register index |
| src_kind_in | input | 2*N_SRC | Packed source kinds |
| src_idx_in | input | IDX_W*N_SRC | Packed source indices |
| flag_wr_in | input | 1 | Instruction writes the condition flag |
| flag_rd_in | input | 1 | Instruction reads the condition flag |
| hazard_out | output | 1 | Registered dependency verdict |
| hazard_cnt_out | output | CNT_W | Saturating count of hazardous pairs |

## Verification
Directed pairs isolate each kind combination. Register against register is tried with equal indices, with different indices and with index zero, which separates a real index compare from a kind-only test. A memory source is tried against a memory destination with different indices, which shows that no address compare takes place. It is also tried against a register destination, which shows the base-register match. Single hits in the second and third slots show that all slots are scanned. A flag pair with no other overlap, and a gap in `valid_in`, test the flag path and the predecessor tracking. Random descriptors with indices drawn from a small range then produce many collisions. A long run of memory pairs, on a narrow counter, drives the counter into saturation.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    OPK_NONE = 2'd0,
    OPK_IMM  = 2'd1,
    OPK_REG  = 2'd2,
    OPK_MEM  = 2'd3
  } opk_t;
endpackage

// File: rtl/hzd_src_cmp.sv
// Compares one source slot of the current instruction against the
// destination of the previous one.
module hzd_src_cmp
  import hzd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [KIND_W-1:0] src_kind,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [KIND_W-1:0] prev_dkind,
  input  logic [IDX_W-1:0]  prev_didx,
  output logic              hit
);
  logic idx_match;
  logic prev_is_reg;
  logic prev_is_mem;

  always_comb begin
    idx_match   = (src_idx == prev_didx) && (src_idx != '0);
    prev_is_reg = (opk_t'(prev_dkind) == OPK_REG);
    prev_is_mem = (opk_t'(prev_dkind) == OPK_MEM);
    case (opk_t'(src_kind))
      OPK_REG: hit = prev_is_reg && idx_match;
      OPK_MEM: hit = prev_is_mem || (prev_is_reg && idx_match);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/hzd_hist.sv
// Holds the destination side of the last valid instruction.
module hzd_hist
  import hzd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [KIND_W-1:0] dkind_in,
  input  logic [IDX_W-1:0]  didx_in,
  input  logic              fwr_in,
  output logic              prev_vld,
  output logic [KIND_W-1:0] prev_dkind,
  output logic [IDX_W-1:0]  prev_didx,
  output logic              prev_fwr
);
  logic              vld_d;
  logic [KIND_W-1:0] dkind_d;
  logic [IDX_W-1:0]  didx_d;
  logic              fwr_d;
  logic              load_en;

  always_comb begin
    load_en = valid_in;
    vld_d   = valid_in;
    dkind_d = prev_dkind;
    didx_d  = prev_didx;
    fwr_d   = prev_fwr;
    if (load_en) begin
      dkind_d = dkind_in;
      didx_d  = didx_in;
      fwr_d   = fwr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld   <= 1'b0;
      prev_dkind <= OPK_NONE;
      prev_didx  <= '0;
      prev_fwr   <= 1'b0;
    end else begin
      prev_vld   <= vld_d;
      prev_dkind <= dkind_d;
      prev_didx  <= didx_d;
      prev_fwr   <= fwr_d;
    end
  end
endmodule

// File: rtl/hzd_satcnt.sv
// Saturating event counter.
module hzd_satcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = inc && (count != CNT_MAX);
    count_d = cnt_en ? count + 1'b1 : count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/operand_hazard_det.sv
module operand_hazard_det
  import hzd_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int N_SRC = 3,
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_in,
  input  logic [1:0]              dst_kind_in,
  input  logic [IDX_W-1:0]        dst_idx_in,
  input  logic [2*N_SRC-1:0]      src_kind_in,
  input  logic [IDX_W*N_SRC-1:0]  src_idx_in,
  input  logic                    flag_wr_in,
  input  logic                    flag_rd_in,
  output logic                    hazard_out,
  output logic [CNT_W-1:0]        hazard_cnt_out
);
  logic              prev_vld;
  logic [KIND_W-1:0] prev_dkind;
  logic [IDX_W-1:0]  prev_didx;
  logic              prev_fwr;
  logic [N_SRC-1:0]  slot_hit;
  logic              pair_ok;
  logic              flag_hit;
  logic              hazard_d;

  hzd_hist #(.IDX_W(IDX_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .dkind_in   (dst_kind_in),
    .didx_in    (dst_idx_in),
    .fwr_in     (flag_wr_in),
    .prev_vld   (prev_vld),
    .prev_dkind (prev_dkind),
    .prev_didx  (prev_didx),
    .prev_fwr   (prev_fwr)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    hzd_src_cmp #(.IDX_W(IDX_W)) u_cmp (
      .src_kind   (src_kind_in[KIND_W*g +: KIND_W]),
      .src_idx    (src_idx_in[IDX_W*g +: IDX_W]),
      .prev_dkind (prev_dkind),
      .prev_didx  (prev_didx),
      .hit        (slot_hit[g])
    );
  end

  always_comb begin
    pair_ok  = valid_in && prev_vld;
    flag_hit = prev_fwr && flag_rd_in;
    hazard_d = pair_ok && ((|slot_hit) || flag_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hazard_out <= 1'b0;
    else        hazard_out <= hazard_d;
  end

  hzd_satcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (hazard_d),
    .count (hazard_cnt_out)
  );
endmodule

// File: rtl/operand_hazard_det_chk.sv
module operand_hazard_det_chk #(
  parameter int N_SRC = 3,
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               valid_in,
  input logic [1:0]         dst_kind_in,
  input logic [2*N_SRC-1:0] src_kind_in,
  input logic               flag_wr_in,
  input logic               flag_rd_in,
  input logic               hazard_out,
  input logic [CNT_W-1:0]   hazard_cnt_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] age;
  logic       any_mem_src;
  logic       any_live_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    any_mem_src  = 1'b0;
    any_live_src = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_kind_in[2*i +: 2] == 2'd3) any_mem_src = 1'b1;
      if (src_kind_in[2*i + 1])          any_live_src = 1'b1;
    end
  end

  AST_NO_IMM_HAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(valid_in) && !$past(any_live_src) && !$past(flag_rd_in))
      |-> !hazard_out); // R2

  AST_REG_VS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(valid_in, 2) && $past(dst_kind_in, 2) == 2'd3 &&
     $past(valid_in) && !$past(any_mem_src) && !$past(flag_rd_in))
      |-> !hazard_out); // R4

  AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(valid_in, 2) && $past(flag_wr_in, 2) &&
     $past(valid_in) && $past(flag_rd_in))
      |-> hazard_out); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !$past(valid_in)) |-> !hazard_out); // R9

  AST_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(valid_in) && !$past(valid_in, 2)) |-> !hazard_out); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && hazard_cnt_out != $past(hazard_cnt_out))
      |-> (hazard_cnt_out == $past(hazard_cnt_out) + 1'b1 && hazard_out)); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(hazard_cnt_out) == CNT_MAX) |-> hazard_cnt_out == CNT_MAX); // R11
endmodule

bind operand_hazard_det operand_hazard_det_chk #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .valid_in       (valid_in),
  .dst_kind_in    (dst_kind_in),
  .src_kind_in    (src_kind_in),
  .flag_wr_in     (flag_wr_in),
  .flag_rd_in     (flag_rd_in),
  .hazard_out     (hazard_out),
  .hazard_cnt_out (hazard_cnt_out)
);

// File: tb/operand_hazard_det_bench.sv
module operand_hazard_det_bench;
  localparam int IDX_W = 5;
  localparam int N_SRC = 3;
  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam logic [1:0] KN = 2'd0, KI = 2'd1, KR = 2'd2, KM = 2'd3;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   valid_in;
  logic [1:0]             dst_kind_in;
  logic [IDX_W-1:0]       dst_idx_in;
  logic [2*N_SRC-1:0]     src_kind_in;
  logic [IDX_W*N_SRC-1:0] src_idx_in;
  logic                   flag_wr_in;
  logic                   flag_rd_in;
  logic                   hazard_out;
  logic [CNT_W-1:0]       hazard_cnt_out;

  int n_chk = 0;
  int n_fail = 0;

  bit         m_pv;
  logic [1:0] m_pdk;
  logic [4:0] m_pdi;
  bit         m_pwf;
  int         m_cnt;

  always #10 clk = ~clk;

  operand_hazard_det #(.IDX_W(IDX_W), .N_SRC(N_SRC), .CNT_W(CNT_W)) u_operand_hazard_det (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .dst_kind_in(dst_kind_in),
    .dst_idx_in(dst_idx_in), .src_kind_in(src_kind_in), .src_idx_in(src_idx_in),
    .flag_wr_in(flag_wr_in), .flag_rd_in(flag_rd_in), .hazard_out(hazard_out),
    .hazard_cnt_out(hazard_cnt_out));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [5:0] ks(input logic [1:0] a, b, c);
    return {c, b, a};
  endfunction

  function automatic logic [14:0] is3(input logic [4:0] a, b, c);
    return {c, b, a};
  endfunction

  // Expected verdict from the requirement rules (R2..R9, R12).
  function automatic bit expect_dep(input bit pv, cv, input logic [1:0] pdk,
                                    input logic [4:0] pdi, input bit pwf,
                                    input logic [5:0] sk, input logic [14:0] si,
                                    input bit rf);
    bit dep = 0;
    for (int i = 0; i < N_SRC; i++) begin
      logic [1:0] k = sk[2*i +: 2];
      logic [4:0] x = si[5*i +: 5];
      bit same = (x == pdi) && (x != 0);
      if (k == KR && pdk == KR && same) dep = 1;
      if (k == KM && (pdk == KM || (pdk == KR && same))) dep = 1;
    end
    if (pwf && rf) dep = 1;
    return pv && cv && dep;
  endfunction

  task automatic apply(input bit v, input logic [1:0] dk, input logic [4:0] di,
                       input logic [5:0] sk, input logic [14:0] si,
                       input bit wf, input bit rf, input string tag);
    bit e;
    @(negedge clk);
    valid_in = v; dst_kind_in = dk; dst_idx_in = di;
    src_kind_in = sk; src_idx_in = si; flag_wr_in = wf; flag_rd_in = rf;
    e = expect_dep(m_pv, v, m_pdk, m_pdi, m_pwf, sk, si, rf);
    if (v) begin m_pdk = dk; m_pdi = di; m_pwf = wf; end
    m_pv = v;
    if (e && m_cnt < CMAX) m_cnt++;
    @(posedge clk); #1;
    check(hazard_out == e, tag, hazard_out, e);
    check(hazard_cnt_out == m_cnt, "R11 count", hazard_cnt_out, m_cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    m_pv = 0; m_pdk = KN; m_pdi = 0; m_pwf = 0; m_cnt = 0;
    rst_n = 1'b0; valid_in = 0; dst_kind_in = KN; dst_idx_in = 0;
    src_kind_in = 0; src_idx_in = 0; flag_wr_in = 0; flag_rd_in = 0;
    repeat (3) @(posedge clk); #1;
    check(hazard_out == 0, "R1 hazard in reset", hazard_out, 0);
    check(hazard_cnt_out == 0, "R1 count in reset", hazard_cnt_out, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(hazard_out == 0 && hazard_cnt_out == 0, "R1 after release", hazard_out, 0);

    apply(1, KR, 7, ks(KN,KN,KN), 0, 0, 0, "R9 first has no predecessor");
    apply(1, KN, 0, ks(KR,KN,KN), is3(7,0,0), 0, 0, "R3 equal index, R10 latency");
    apply(1, KR, 9, ks(KR,KN,KN), is3(7,0,0), 0, 0, "R3 no destination before");
    apply(1, KN, 0, ks(KI,KI,KI), is3(9,9,9), 0, 0, "R2 immediates");
    apply(1, KR, 4, 0, 0, 0, 0, "R3 setup");
    apply(1, KR, 0, ks(KR,KN,KN), is3(8,0,0), 0, 0, "R3 different index");
    apply(1, KN, 0, ks(KR,KM,KN), is3(0,0,0), 0, 0, "R8 register zero");
    apply(1, KM, 5, 0, 0, 0, 0, "R4 setup");
    apply(1, KN, 0, ks(KR,KN,KN), is3(5,0,0), 0, 0, "R4 reg after mem");
    apply(1, KM, 5, 0, 0, 0, 0, "R5 setup");
    apply(1, KN, 0, ks(KM,KN,KN), is3(12,0,0), 0, 0, "R5 mem after mem");
    apply(1, KR, 6, 0, 0, 0, 0, "R6 setup");
    apply(1, KN, 0, ks(KN,KN,KM), is3(0,0,6), 0, 0, "R6 R12 base match slot 2");
    apply(1, KR, 11, 0, 0, 0, 0, "R12 setup");
    apply(1, KN, 0, ks(KI,KR,KI), is3(0,11,0), 0, 0, "R12 slot 1");
    apply(1, KN, 0, 0, 0, 1, 0, "R7 setup");
    apply(1, KN, 0, ks(KI,KN,KN), 0, 0, 1, "R7 flag pair");
    apply(1, KR, 3, 0, 0, 1, 0, "R9 setup");
    apply(0, KN, 0, ks(KR,KN,KN), is3(3,0,0), 0, 1, "R9 invalid cycle");
    apply(1, KN, 0, ks(KR,KN,KN), is3(3,0,0), 0, 1, "R9 after gap");

    for (int n = 0; n < 400; n++) begin
      logic [5:0]  rk = 6'($urandom);
      logic [14:0] ri = 0;
      for (int j = 0; j < N_SRC; j++) ri[5*j +: 5] = 5'($urandom % 4);
      apply(($urandom % 5) != 0, 2'($urandom), 5'($urandom % 4), rk, ri,
            1'($urandom % 3 == 0), 1'($urandom % 3 == 0), "R12 random");
    end

    for (int n = 0; n < 70; n++)
      apply(1, KM, 1, ks(KM,KN,KN), is3(2,0,0), 0, 0, "R5 pump");
    check(hazard_cnt_out == CMAX, "R11 saturated", hazard_cnt_out, CMAX);
    apply(1, KM, 1, ks(KM,KN,KN), 0, 0, 0, "R11 hold at max");
    finish_run();
  end
endmodule